// File: doc/BRIEF.md
# DDR2 SDRAM Start-Up Sequencer

This block takes a DDR2 SDRAM from a cold, clocked state to a usable state. It waits for a power-good input that reports stable supplies and a running clock. It keeps the clock enable low while it holds the first long wait, raises the clock enable, and waits again. It then drives the fixed start-up command list onto the memory's command, bank-address and address pins. That list consists of a precharge of all banks and the four mode register loads, which enable and then reset the DLL. After those come a second precharge, a configurable number of refreshes and a dummy write. The dummy write is held back until the DLL has had time to lock.

Every wait is given in picoseconds or in clock cycles. Cycle counts are derived from a clock-period parameter. The contents of each mode register come from parameters, apart from the bits that the start-up procedure fixes. Once the last command and its recovery time have passed, the block raises a done flag and hands all memory pins straight through from the controller's inputs. A loss of power-good at any point returns the block to the first wait.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and while power-good is low, clock enable is low, done is low and the command pins {cs_n,ras_n,cas_n,we_n} hold NOP = 4'b0111. Clock enable rises no sooner than INIT_CYC = ceil(T_INIT_PS/CLK_PERIOD_PS) cycles after power-good rises.
- R2: The first command is PRECHARGE (4'b0010) with address bit 10 high, meaning all banks. It comes at least CKE_CYC = ceil(T_CKE_PS/CLK_PERIOD_PS) cycles after clock enable rises.
- R3: Next come four LOAD MODE commands (4'b0000), in this order of bank address: 2, 3, 1, 0. Bank 2 carries EMR2_VAL and bank 3 carries EMR3_VAL unchanged.
- R4: The bank-1 load carries EMR_VAL with address bits 0, 7, 8 and 9 forced to 0, so the DLL is enabled.
- R5: The bank-0 load carries MR_VAL with address bit 8 forced to 1, so the DLL is reset.
- R6: After the bank-0 load come PRECHARGE with bit 10 high, then N_REF REFRESH commands (4'b0001), then one WRITE (4'b0100) with bank 0 and address 0. No other command is issued.
- R7: Only NOP appears between commands. The spacing from a command to the next one is exactly RP_CYC after a precharge, T_MRD_CYC after a mode load and RFC_CYC after a refresh. RP_CYC and RFC_CYC are the ceilings of T_RP_PS and T_RFC_PS over the clock period.
- R8: The WRITE comes exactly max(RFC_CYC, DLL_LOCK_CYC − cycles elapsed since the bank-0 load at the last refresh) cycles after the last refresh. It is therefore never sooner than DLL_LOCK_CYC cycles after the DLL reset.
- R9: Once clock enable is high, it stays high until done while power-good stays high.
- R10: Done rises exactly T_WR_CYC cycles after the WRITE and stays high. While done is high, every memory pin equals the matching controller input.
- R11: When power-good is low at a clock edge, done and clock enable are low and NOP is driven after that edge. When power-good returns, the whole sequence restarts from the first wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock are stable |
| ctl_cke | input | 1 | Controller clock enable, passed through after done |
| ctl_cs_n | input | 1 | Controller chip select, passed through after done |
| ctl_ras_n | input | 1 | Controller row strobe, passed through after done |
| ctl_cas_n | input | 1 | Controller column strobe, passed through after done |
| ctl_we_n | input | 1 | Controller write enable, passed through after done |
| ctl_ba | input | BA_W | Controller bank address, passed through after done |
| ctl_addr | input | ADDR_W | Controller address, passed through after done |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Memory chip select |
| ddr_ras_n | output | 1 | Memory row strobe |
| ddr_cas_n | output | 1 | Memory column strobe |
| ddr_we_n | output | 1 | Memory write enable |
| ddr_ba | output | BA_W | Memory bank address |
| ddr_addr | output | ADDR_W | Memory address |
| init_done | output | 1 | Start-up complete; pins belong to the controller |

## Verification
The assertions check, on every cycle, the properties that do not depend on position in the sequence:
- only NOP is driven while clock enable is low;
- every precharge covers all banks;
- the DLL bits are correct in the bank-1 and bank-0 mode loads;
- clock enable never drops before done;
- done is sticky;
- a power-good loss clears done and clock enable on the next edge.

The order of commands, the exact cycle spacing of each gap, the DLL lock hold on the write, the done timing, the pass-through and a restart in mid-sequence can only be shown by the bench's scenarios, which compare each issued command against a queue of expected items.

// File: rtl/ddr2_init_pkg.sv
// Package: shared command encodings and sequencer states for the DDR2 start-up block.
// Assumes the command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_WR  = 4'b0100,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWR,
        ST_CKE,
        ST_RUN,
        ST_DONE
    } seq_state_e;

    // Mode-register bank selections; the memory decodes these, so they are fixed.
    localparam int BA_EMR2 = 2;
    localparam int BA_EMR3 = 3;
    localparam int BA_EMR  = 1;
    localparam int BA_MR   = 0;

endpackage

// File: rtl/init_delay_timer.sv
// Module: loadable down-counter that reports busy while its count is non-zero.
// Assumes a load value of N keeps busy high for the next N edges' checks.
module init_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Busy flag seen by the sequencer.
    always_comb busy = (cnt != '0);

endmodule

// File: rtl/init_step_decode.sv
// Module: maps a start-up step index to its command, bank, address and following gap.
// Assumes steps are 0 PRE, 1..4 mode loads, 5 PRE, then N_REF refreshes, then WRITE.
module init_step_decode
    import ddr2_init_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter int          BA_W     = 2,
    parameter int          TMR_W    = 16,
    parameter int          SW       = 4,
    parameter int          N_REF    = 2,
    parameter int          RP_CYC   = 2,
    parameter int          MRD_CYC  = 2,
    parameter int          RFC_CYC  = 13,
    parameter int          WR_CYC   = 4,
    parameter [ADDR_W-1:0] EMR2_VAL = '0,
    parameter [ADDR_W-1:0] EMR3_VAL = '0,
    parameter [ADDR_W-1:0] EMR_VAL  = '0,
    parameter [ADDR_W-1:0] MR_VAL   = '0
) (
    input  logic [SW-1:0]     step,
    output ddr_cmd_e          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [TMR_W-1:0]  gap,
    output logic              is_mr,
    output logic              is_wr
);

    localparam [ADDR_W-1:0] A10_ALL  = ADDR_W'(1) << 10;
    localparam [ADDR_W-1:0] EMR_CLR  = ADDR_W'('h381);
    localparam [ADDR_W-1:0] A8_RST   = ADDR_W'(1) << 8;
    localparam int          REF_LAST = 6 + N_REF;

    // Select the step's command fields and recovery gap.
    always_comb begin
        cmd   = CMD_NOP;
        ba    = '0;
        addr  = '0;
        gap   = TMR_W'(1);
        is_mr = 1'b0;
        is_wr = 1'b0;
        if (step == SW'(0) || step == SW'(5)) begin
            cmd  = CMD_PRE;
            addr = A10_ALL;
            gap  = TMR_W'(RP_CYC);
        end else if (step == SW'(1)) begin
            cmd  = CMD_LMR;
            ba   = BA_W'(BA_EMR2);
            addr = EMR2_VAL;
            gap  = TMR_W'(MRD_CYC);
        end else if (step == SW'(2)) begin
            cmd  = CMD_LMR;
            ba   = BA_W'(BA_EMR3);
            addr = EMR3_VAL;
            gap  = TMR_W'(MRD_CYC);
        end else if (step == SW'(3)) begin
            cmd  = CMD_LMR;
            ba   = BA_W'(BA_EMR);
            addr = EMR_VAL & ~EMR_CLR;
            gap  = TMR_W'(MRD_CYC);
        end else if (step == SW'(4)) begin
            cmd   = CMD_LMR;
            ba    = BA_W'(BA_MR);
            addr  = MR_VAL | A8_RST;
            gap   = TMR_W'(MRD_CYC);
            is_mr = 1'b1;
        end else if (step < SW'(REF_LAST)) begin
            cmd = CMD_REF;
            gap = TMR_W'(RFC_CYC);
        end else if (step == SW'(REF_LAST)) begin
            cmd   = CMD_WR;
            gap   = TMR_W'(WR_CYC);
            is_wr = 1'b1;
        end
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// Module: DDR2 start-up sequencer top. It waits for power-good, runs the timed clock-enable
// phases, steps through the command list with timed gaps and then hands the pins over.
// Assumes pwr_ok is synchronous to clk, N_REF >= 2 and ADDR_W >= 11.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int          ADDR_W        = 14,
    parameter int          BA_W          = 2,
    parameter int          CLK_PERIOD_PS = 10000,
    parameter int          T_INIT_PS     = 200_000_000,
    parameter int          T_CKE_PS      = 400_000,
    parameter int          T_RP_PS       = 15_000,
    parameter int          T_RFC_PS      = 127_500,
    parameter int          T_MRD_CYC     = 2,
    parameter int          T_WR_CYC      = 4,
    parameter int          DLL_LOCK_CYC  = 200,
    parameter int          N_REF         = 2,
    parameter [ADDR_W-1:0] EMR2_VAL      = '0,
    parameter [ADDR_W-1:0] EMR3_VAL      = '0,
    parameter [ADDR_W-1:0] EMR_VAL       = ADDR_W'('h0044),
    parameter [ADDR_W-1:0] MR_VAL        = ADDR_W'('h0632)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              ctl_cke,
    input  logic              ctl_cs_n,
    input  logic              ctl_ras_n,
    input  logic              ctl_cas_n,
    input  logic              ctl_we_n,
    input  logic [BA_W-1:0]   ctl_ba,
    input  logic [ADDR_W-1:0] ctl_addr,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);

    localparam int INIT_CYC  = (T_INIT_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int CKE_CYC   = (T_CKE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RP_RAW    = (T_RP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RFC_RAW   = (T_RFC_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RP_CYC    = (RP_RAW < 1) ? 1 : RP_RAW;
    localparam int RFC_CYC   = (RFC_RAW < 1) ? 1 : RFC_RAW;
    localparam int MRD_CYC   = (T_MRD_CYC < 1) ? 1 : T_MRD_CYC;
    localparam int WR_CYC    = (T_WR_CYC < 1) ? 1 : T_WR_CYC;
    localparam int DLL_CYC   = (DLL_LOCK_CYC < 1) ? 1 : DLL_LOCK_CYC;
    localparam int TMR_W     = $clog2(INIT_CYC + CKE_CYC + RFC_CYC + DLL_CYC + WR_CYC + 2);
    localparam int NUM_STEPS = 7 + N_REF;
    localparam int SW        = $clog2(NUM_STEPS + 1);

    generate
        if (N_REF < 2) begin : g_ref_check
            $error("N_REF must be at least 2");
        end
    endgenerate

    seq_state_e        state;
    logic [SW-1:0]     step;
    ddr_cmd_e          cmd_q;
    logic [BA_W-1:0]   ba_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cke_q;
    logic              done_q;

    ddr_cmd_e          dec_cmd;
    logic [BA_W-1:0]   dec_ba;
    logic [ADDR_W-1:0] dec_addr;
    logic [TMR_W-1:0]  dec_gap;
    logic              dec_is_mr;
    logic              dec_is_wr;

    logic              tmr_load, tmr_busy;
    logic [TMR_W-1:0]  tmr_val;
    logic              dll_load, dll_busy;
    logic [TMR_W-1:0]  dll_val;
    logic              issue;
    logic              seq_end;

    init_step_decode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .TMR_W(TMR_W), .SW(SW), .N_REF(N_REF),
        .RP_CYC(RP_CYC), .MRD_CYC(MRD_CYC), .RFC_CYC(RFC_CYC), .WR_CYC(WR_CYC),
        .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL), .EMR_VAL(EMR_VAL), .MR_VAL(MR_VAL)
    ) u_dec (
        .step(step), .cmd(dec_cmd), .ba(dec_ba), .addr(dec_addr),
        .gap(dec_gap), .is_mr(dec_is_mr), .is_wr(dec_is_wr)
    );

    init_delay_timer #(.W(TMR_W)) u_gap_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(tmr_busy)
    );

    init_delay_timer #(.W(TMR_W)) u_dll_tmr (
        .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(dll_val), .busy(dll_busy)
    );

    always_comb seq_end = (step == SW'(NUM_STEPS));

    // Decide timer reloads and whether a command goes out at this edge.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        dll_load = 1'b0;
        dll_val  = '0;
        issue    = 1'b0;
        if (!pwr_ok) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(INIT_CYC);
            dll_load = 1'b1;
        end else begin
            case (state)
                ST_OFF: begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(INIT_CYC);
                end
                ST_PWR: if (!tmr_busy) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(CKE_CYC);
                end
                ST_RUN: if (!tmr_busy && !seq_end && !(dec_is_wr && dll_busy)) begin
                    issue    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = dec_gap - 1'b1;
                    if (dec_is_mr) begin
                        dll_load = 1'b1;
                        dll_val  = TMR_W'(DLL_CYC - 1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state, step index and registered pin values.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            state  <= ST_OFF;
            step   <= '0;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_OFF: state <= ST_PWR;
                ST_PWR: if (!tmr_busy) begin
                    state <= ST_CKE;
                    cke_q <= 1'b1;
                end
                ST_CKE: if (!tmr_busy) state <= ST_RUN;
                ST_RUN: begin
                    cmd_q  <= issue ? dec_cmd : CMD_NOP;
                    ba_q   <= issue ? dec_ba : '0;
                    addr_q <= issue ? dec_addr : '0;
                    if (issue) step <= step + 1'b1;
                    if (seq_end && !tmr_busy) begin
                        state  <= ST_DONE;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Hand the pins to the controller once start-up is complete.
    always_comb begin
        if (done_q) begin
            ddr_cke = ctl_cke;
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n};
            ddr_ba   = ctl_ba;
            ddr_addr = ctl_addr;
        end else begin
            ddr_cke = cke_q;
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
            ddr_ba   = ba_q;
            ddr_addr = addr_q;
        end
        init_done = done_q;
    end

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Module: property checker for the start-up sequencer, bound to every instance.
// Assumes the same ADDR_W and BA_W as the bound instance.
module ddr2_init_seq_chk #(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              ddr_cke,
    input logic              ddr_cs_n,
    input logic              ddr_ras_n,
    input logic              ddr_cas_n,
    input logic              ddr_we_n,
    input logic [BA_W-1:0]   ddr_ba,
    input logic [ADDR_W-1:0] ddr_addr,
    input logic              init_done
);

    logic [3:0] pins;
    always_comb pins = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

    AST_NOP_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_cke && !init_done) |-> (pins == 4'b0111)); // R1
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && pins == 4'b0010) |-> ddr_addr[10]); // R2
    AST_EMR_DLL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && pins == 4'b0000 && ddr_ba == BA_W'(1))
        |-> ((ddr_addr & ADDR_W'('h381)) == '0)); // R4
    AST_MR_DLL_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && pins == 4'b0000 && ddr_ba == '0) |-> ddr_addr[8]); // R5
    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && ddr_cke && !init_done) |=> (ddr_cke || init_done)); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && init_done) |=> init_done); // R10
    AST_PWR_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!init_done && !ddr_cke && pins == 4'b0111)); // R11

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/tb_ddr2_init_seq.sv
// Bench: scoreboard of expected start-up commands, checked by a monitor at each falling edge.
module tb_ddr2_init_seq;

    localparam int CLK_PS = 10000;
    localparam int T_INIT = 200_000_000;
    localparam int T_CKE  = 400_000;
    localparam int T_RP   = 15_000;
    localparam int T_RFC  = 127_500;
    localparam int MRD    = 2;
    localparam int TWR    = 4;
    localparam int DLL    = 200;
    localparam int NREF   = 3;
    localparam logic [13:0] EMR2 = 14'h0080;
    localparam logic [13:0] EMR3 = 14'h0000;
    localparam logic [13:0] EMR  = 14'h03C5;
    localparam logic [13:0] MR   = 14'h0242;
    localparam int INIT_C = 20000;
    localparam int CKE_C  = 40;
    localparam int RP_C   = 2;
    localparam int RFC_C  = 13;
    localparam int N_ITEMS = 7 + NREF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_ok = 1'b0;
    logic        ctl_cke = 1'b1, ctl_cs_n = 1'b0, ctl_ras_n = 1'b1, ctl_cas_n = 1'b1, ctl_we_n = 1'b1;
    logic [1:0]  ctl_ba = '0;
    logic [13:0] ctl_addr = '0;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
    logic [1:0]  ddr_ba;
    logic [13:0] ddr_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [13:0] addr;
        int          gap;
        bit          exact;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    ddr2_init_seq #(
        .ADDR_W(14), .BA_W(2), .CLK_PERIOD_PS(CLK_PS), .T_INIT_PS(T_INIT), .T_CKE_PS(T_CKE),
        .T_RP_PS(T_RP), .T_RFC_PS(T_RFC), .T_MRD_CYC(MRD), .T_WR_CYC(TWR),
        .DLL_LOCK_CYC(DLL), .N_REF(NREF), .EMR2_VAL(EMR2), .EMR3_VAL(EMR3),
        .EMR_VAL(EMR), .MR_VAL(MR)
    ) dut (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input int b, input logic [13:0] a, input int g,
                        input bit ex, input string t);
        exp_t e;
        e.cmd = c; e.ba = 2'(b); e.addr = a; e.gap = g; e.exact = ex; e.tag = t;
        exp_q.push_back(e);
    endtask

    // Driver: expected start-up list worked out from the requirements.
    task automatic push_sequence();
        int elapsed;
        int wgap;
        exp_q.delete();
        push(4'b0010, 0, 14'h0400, CKE_C, 1'b0, "R2");
        push(4'b0000, 2, EMR2, RP_C, 1'b1, "R3");
        push(4'b0000, 3, EMR3, MRD, 1'b1, "R3");
        push(4'b0000, 1, 14'h0044, MRD, 1'b1, "R4");
        push(4'b0000, 0, 14'h0342, MRD, 1'b1, "R5");
        push(4'b0010, 0, 14'h0400, MRD, 1'b1, "R6");
        push(4'b0001, 0, 14'h0000, RP_C, 1'b1, "R7");
        for (int i = 1; i < NREF; i++) push(4'b0001, 0, 14'h0000, RFC_C, 1'b1, "R7");
        elapsed = MRD + RP_C + (NREF - 1) * RFC_C;
        wgap = (DLL - elapsed > RFC_C) ? DLL - elapsed : RFC_C;
        push(4'b0100, 0, 14'h0000, wgap, 1'b1, "R8");
    endtask

    int  pwr_rise_cyc = 0, cke_rise_cyc = 0, last_cyc = 0, wr_cyc = 0;
    bit  cke_prev = 0, done_prev = 0, pwr_prev = 0, first_cmd = 1;

    // Monitor: pops and compares each issued command, times clock enable and done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ddr_cke && !cke_prev && !init_done) begin
                cke_rise_cyc = cyc;
                check(cyc - pwr_rise_cyc >= INIT_C, "R1", "cke rise delay", cyc - pwr_rise_cyc, INIT_C);
            end
            if (cke_prev && !ddr_cke && !init_done && pwr_prev)
                check(1'b0, "R9", "cke dropped before done", 0, 1);
            if (!init_done && {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} != 4'b0111) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected command", int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 7);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == e.cmd, e.tag, "command",
                          int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), int'(e.cmd));
                    check(ddr_ba == e.ba, e.tag, "bank", int'(ddr_ba), int'(e.ba));
                    check(ddr_addr == e.addr, e.tag, "address", int'(ddr_addr), int'(e.addr));
                    if (first_cmd)
                        check(cyc - cke_rise_cyc >= e.gap, "R2", "cke to precharge", cyc - cke_rise_cyc, e.gap);
                    else
                        check(cyc - last_cyc == e.gap, e.tag, "spacing", cyc - last_cyc, e.gap);
                    first_cmd = 0;
                    last_cyc = cyc;
                    if (e.cmd == 4'b0100) wr_cyc = cyc;
                end
            end
            if (init_done && !done_prev) begin
                check(cyc - wr_cyc == TWR, "R10", "done after write", cyc - wr_cyc, TWR);
                check(exp_q.size() == 0, "R6", "items left at done", exp_q.size(), 0);
            end
        end
        cke_prev  = ddr_cke;
        done_prev = init_done;
        pwr_prev  = pwr_ok;
    end

    task automatic raise_power();
        @(posedge clk); #2;
        first_cmd = 1;
        pwr_rise_cyc = cyc;
        pwr_ok = 1'b1;
    endtask

    task automatic drop_and_check(input string what);
        @(posedge clk); #2;
        pwr_ok = 1'b0;
        @(negedge clk); @(negedge clk);
        check(!init_done, "R11", {what, " done"}, int'(init_done), 0);
        check(!ddr_cke, "R11", {what, " cke"}, int'(ddr_cke), 0);
        check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111, "R11", {what, " nop"},
              int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 7);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!ddr_cke, "R1", "reset cke", int'(ddr_cke), 0);
        check(!init_done, "R1", "reset done", int'(init_done), 0);
        check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111, "R1", "reset nop",
              int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 7);

        // Full sequence from a cold start.
        push_sequence();
        raise_power();
        wait (init_done);
        repeat (2) @(negedge clk);

        // Pass-through once done (R10).
        @(posedge clk); #2;
        ctl_cke = 1'b0; ctl_cs_n = 1'b0; ctl_ras_n = 1'b1; ctl_cas_n = 1'b0; ctl_we_n = 1'b1;
        ctl_ba = 2'd2; ctl_addr = 14'h1234;
        @(negedge clk);
        check(ddr_cke == 1'b0, "R10", "pass cke", int'(ddr_cke), 0);
        check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0101, "R10", "pass cmd",
              int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 5);
        check(ddr_ba == 2'd2 && ddr_addr == 14'h1234, "R10", "pass addr", int'(ddr_addr), 'h1234);
        @(posedge clk); #2;
        ctl_cke = 1'b1; ctl_cs_n = 1'b0; ctl_ras_n = 1'b1; ctl_cas_n = 1'b1; ctl_we_n = 1'b1;
        ctl_ba = '0; ctl_addr = '0;

        // Power loss after done.
        drop_and_check("after done");

        // Power loss in mid-sequence, after the bank-3 load.
        push_sequence();
        raise_power();
        wait (exp_q.size() <= N_ITEMS - 3);
        drop_and_check("mid sequence");
        repeat (10) @(negedge clk);
        check(!ddr_cke, "R11", "stays off while low", int'(ddr_cke), 0);

        // Full restart.
        push_sequence();
        raise_power();
        wait (init_done);
        repeat (3) @(negedge clk);
        check(init_done, "R10", "done held", int'(init_done), 1);
        summary();
    end

endmodule